// File: doc/BRIEF.md
# DSI Video-Mode Display Timing Recovery

This block sits behind a DSI receiver and rebuilds display timing from the byte stream itself. Each byte clock delivers at most one byte (`byteValid`), and `pktStart` marks the first byte of every packet. The block reads each packet header: the data type, the 16-bit word count and the ECC byte. It steps through long-packet payloads and their two checksum bytes. From specific header and payload positions it raises and drops horizontal sync, vertical sync and the data-enable window. ECC and checksum bytes are counted but never checked.

The width of horizontal sync is not carried in the stream. It is set by `hsWidth` and counted in pixel-rate enable pulses. Those pulses come from dividing the byte clock by `pixDiv`. The start of the data-enable window depends on the transmission style. With `burstMode` low, the non-burst rule applies: the window opens a fixed number of payload bytes late, so that it covers the same length as the pixel data even though the trailing checksum is counted. With `burstMode` high, the window opens on the first payload byte, and the idle time after the pixel packet is left to the sender. In both modes the window closes on the ECC byte of the next blanking packet.

Top module: `dsiVidTiming`

## Requirements
- R1: While `rstN` is low, `hsync`, `vsync`, `de` and `pixEn` are all low.
- R2: A byte counts only when `byteValid` is high. A counted byte with `pktStart` high is header byte 0, and its low 6 bits are the data type (the upper 2 bits are ignored). Header bytes 1 and 2 are the word count, least-significant byte first. Header byte 3 is the ECC byte.
- R3: `hsync` rises at the clock edge that accepts the ECC byte of a type 0x21 packet (the line-start sync packet).
- R4: `hsync` stays high for exactly `hsWidth` cycles in which both `hsync` and `pixEn` are high, then falls. A type 0x31 packet (line-end sync) has no effect on `hsync`.
- R5: `vsync` rises at the clock edge that accepts the ECC byte of a type 0x01 packet. It falls at the clock edge that accepts the ECC byte of a type 0x11 packet.
- R6: `pixEn` is a single-cycle pulse that repeats every `pixDiv` clock cycles.
- R7: With `burstMode` low, `de` rises at the clock edge that accepts the sixth payload byte of a type 0x3E pixel packet.
- R8: With `burstMode` high, `de` rises at the clock edge that accepts the first payload byte of a type 0x3E pixel packet.
- R9: `de` falls at the clock edge that accepts the ECC byte of a type 0x19 blanking packet. A blanking packet that arrives while `de` is low has no effect on `de`.
- R10: A packet is long when its type's low nibble is 0x9 or 0xE. For a long packet, the block skips word-count payload bytes plus 2 checksum bytes. Payload bytes never act as headers. A long packet of any type other than 0x3E never opens `de`.
- R11: With `burstMode` low, a pixel packet with fewer than six payload bytes leaves `de` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteIn | input | 8 | Received stream byte |
| byteValid | input | 1 | `byteIn` carries a byte this cycle |
| pktStart | input | 1 | This byte is the first byte of a packet |
| burstMode | input | 1 | 1 selects the burst-mode rule for the start of DE |
| hsWidth | input | HSW_W | Width of the horizontal sync pulse, in pixel enables |
| pixDiv | input | DIV_W | Byte clocks per pixel clock |
| hsync | output | 1 | Recovered horizontal sync |
| vsync | output | 1 | Recovered vertical sync |
| de | output | 1 | Data-enable window |
| pixEn | output | 1 | Pixel-rate enable pulse |

## Verification
The bench keeps the default widths (8-bit `hsWidth`, 4-bit `pixDiv`, six-byte delay for the start of DE). It drives a divider of 4 with a sync width of 3 in non-burst lines, then a divider of 3 with a width of 5 in burst lines. Both settings leave room for a sync pulse to end before the next packet. This makes the width count and the `pixEn` spacing visible under two ratios.

Each line carries enough payload for DE to open under both rules. The bench also covers a short pixel packet, a non-pixel long packet, a pause in `byteValid` inside a payload, and payload bytes that look like sync headers. This exercises the skip through payload and checksum, and every edge rule.

// File: rtl/dsiVtPkg.sv
package dsiVtPkg;
  localparam int WC_W = 16;

  localparam logic [5:0] DT_VSYNC_ON  = 6'h01;
  localparam logic [5:0] DT_VSYNC_OFF = 6'h11;
  localparam logic [5:0] DT_HSYNC_ON  = 6'h21;
  localparam logic [5:0] DT_HSYNC_OFF = 6'h31;
  localparam logic [5:0] DT_BLANK     = 6'h19;
  localparam logic [5:0] DT_RGB24     = 6'h3E;

  typedef struct packed {
    logic hsOn;
    logic vsOn;
    logic vsOff;
    logic blankEcc;
    logic deStart;
  } vtStrobe_t;

  typedef enum logic [1:0] {PS_IDLE, PS_HDR, PS_PAY, PS_CRC} parseState_t;
endpackage

// File: rtl/dsiPktCtrl.sv
module dsiPktCtrl
  import dsiVtPkg::*;
#(
  parameter int DE_DELAY = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  byteIn,
  input  logic        byteValid,
  input  logic        pktStart,
  input  logic        burstMode,
  output vtStrobe_t   stb
);
  localparam int CNT_W = $clog2(DE_DELAY + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DE_DELAY - 1);
  localparam logic [CNT_W-1:0] DLY_SAT  = CNT_W'(DE_DELAY);

  parseState_t       state;
  logic [5:0]        dataType;
  logic [1:0]        hdrIdx;
  logic [7:0]        wcLo;
  logic [7:0]        wcHi;
  logic [WC_W-1:0]   remain;
  logic [CNT_W-1:0]  payCnt;
  logic              isRgb;
  logic              crcSecond;

  logic accept;
  logic hdrEcc;
  logic isLong;
  logic payByte;

  assign accept  = byteValid && !pktStart;
  assign hdrEcc  = accept && (state == PS_HDR) && (hdrIdx == 2'd3);
  assign isLong  = (dataType[3:0] == 4'h9) || (dataType[3:0] == 4'hE);
  assign payByte = accept && (state == PS_PAY);

  always_comb begin
    stb          = '0;
    stb.hsOn     = hdrEcc && (dataType == DT_HSYNC_ON);
    stb.vsOn     = hdrEcc && (dataType == DT_VSYNC_ON);
    stb.vsOff    = hdrEcc && (dataType == DT_VSYNC_OFF);
    stb.blankEcc = hdrEcc && (dataType == DT_BLANK);
    stb.deStart  = payByte && isRgb &&
                   (burstMode ? (payCnt == '0) : (payCnt == DLY_LAST));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= PS_IDLE;
      dataType  <= '0;
      hdrIdx    <= '0;
      wcLo      <= '0;
      wcHi      <= '0;
      remain    <= '0;
      payCnt    <= '0;
      isRgb     <= 1'b0;
      crcSecond <= 1'b0;
    end else if (byteValid && pktStart) begin
      state    <= PS_HDR;
      dataType <= byteIn[5:0];
      hdrIdx   <= 2'd1;
    end else if (byteValid) begin
      unique case (state)
        PS_HDR: begin
          hdrIdx <= hdrIdx + 2'd1;
          if (hdrIdx == 2'd1) wcLo <= byteIn;
          if (hdrIdx == 2'd2) wcHi <= byteIn;
          if (hdrIdx == 2'd3) begin
            if (isLong) begin
              remain    <= {wcHi, wcLo};
              payCnt    <= '0;
              isRgb     <= (dataType == DT_RGB24);
              crcSecond <= 1'b0;
              state     <= ({wcHi, wcLo} == '0) ? PS_CRC : PS_PAY;
            end else begin
              state <= PS_IDLE;
            end
          end
        end
        PS_PAY: begin
          if (payCnt != DLY_SAT) payCnt <= payCnt + 1'b1;
          remain <= remain - 1'b1;
          if (remain == WC_W'(1)) begin
            state     <= PS_CRC;
            crcSecond <= 1'b0;
          end
        end
        PS_CRC: begin
          if (crcSecond) state <= PS_IDLE;
          else           crcSecond <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dsiTimingDp.sv
module dsiTimingDp
  import dsiVtPkg::*;
#(
  parameter int HSW_W = 8,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  vtStrobe_t        stb,
  input  logic [HSW_W-1:0] hsWidth,
  input  logic [DIV_W-1:0] pixDiv,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             pixEn
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimit;
  logic             divWrap;
  logic [HSW_W-1:0] hsLeft;

  assign divLimit = (pixDiv == '0) ? '0 : pixDiv - DIV_W'(1);
  assign divWrap  = (divCnt >= divLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      pixEn  <= 1'b0;
    end else begin
      divCnt <= divWrap ? '0 : divCnt + 1'b1;
      pixEn  <= divWrap;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsync  <= 1'b0;
      hsLeft <= '0;
    end else if (stb.hsOn) begin
      hsync  <= 1'b1;
      hsLeft <= (hsWidth == '0) ? HSW_W'(1) : hsWidth;
    end else if (hsync && pixEn) begin
      if (hsLeft <= HSW_W'(1)) hsync <= 1'b0;
      else                     hsLeft <= hsLeft - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          vsync <= 1'b0;
    else if (stb.vsOn)  vsync <= 1'b1;
    else if (stb.vsOff) vsync <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             de <= 1'b0;
    else if (stb.blankEcc) de <= 1'b0;
    else if (stb.deStart)  de <= 1'b1;
  end
endmodule

// File: rtl/dsiVidTiming.sv
module dsiVidTiming
  import dsiVtPkg::*;
#(
  parameter int HSW_W    = 8,
  parameter int DIV_W    = 4,
  parameter int DE_DELAY = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       byteIn,
  input  logic             byteValid,
  input  logic             pktStart,
  input  logic             burstMode,
  input  logic [HSW_W-1:0] hsWidth,
  input  logic [DIV_W-1:0] pixDiv,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             pixEn
);
  vtStrobe_t stb;

  dsiPktCtrl #(.DE_DELAY(DE_DELAY)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteIn(byteIn), .byteValid(byteValid),
    .pktStart(pktStart), .burstMode(burstMode), .stb(stb)
  );

  dsiTimingDp #(.HSW_W(HSW_W), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hsWidth(hsWidth), .pixDiv(pixDiv),
    .hsync(hsync), .vsync(vsync), .de(de), .pixEn(pixEn)
  );
endmodule

// File: rtl/dsiVidTimingChk.sv
module dsiVidTimingChk
  import dsiVtPkg::*;
#(
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             hsync,
  input logic             vsync,
  input logic             de,
  input logic             pixEn,
  input logic [DIV_W-1:0] pixDiv,
  input vtStrobe_t        stb
);
  p_hs_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsync) |-> $past(stb.hsOn));

  p_hs_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hsync) |-> $past(pixEn));

  p_vs_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vsync) |-> $past(stb.vsOn));

  p_vs_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vsync) |-> $past(stb.vsOff));

  p_pix_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && (pixDiv > DIV_W'(1)) && $stable(pixDiv)) |=> !pixEn);

  p_de_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(de) |-> $past(stb.deStart));

  p_de_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(de) |-> $past(stb.blankEcc));
endmodule

bind dsiVidTiming dsiVidTimingChk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rstN(rstN), .hsync(hsync), .vsync(vsync), .de(de),
  .pixEn(pixEn), .pixDiv(pixDiv), .stb(stb)
);

// File: tb/sim_dsiVidTiming.sv
module sim_dsiVidTiming;
  localparam int K_HSR = 0, K_VSR = 1, K_VSF = 2, K_DER = 3, K_DEF = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] byteIn = '0;
  logic       byteValid = 1'b0;
  logic       pktStart = 1'b0;
  logic       burstMode = 1'b0;
  logic [7:0] hsWidth = 8'd3;
  logic [3:0] pixDiv = 4'd4;
  logic       hsync, vsync, de, pixEn;

  int     nCmp = 0;
  int     nBad = 0;
  longint edgeNo = 0;
  int     qKind[$];
  longint qEdge[$];
  bit     expDe = 0;
  bit     expVs = 0;
  bit     pixRestart = 1;
  bit     done = 0;

  dsiVidTiming u0 (
    .clk(clk), .rstN(rstN), .byteIn(byteIn), .byteValid(byteValid),
    .pktStart(pktStart), .burstMode(burstMode), .hsWidth(hsWidth),
    .pixDiv(pixDiv), .hsync(hsync), .vsync(vsync), .de(de), .pixEn(pixEn)
  );

  always #5 clk = ~clk;
  always @(posedge clk) edgeNo <= edgeNo + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edgeNo);
    end
  endtask

  task automatic expectEvt(input int kind, input string req);
    if (qKind.size() == 0) begin
      chk(0, req, kind, -1);
    end else begin
      int     k = qKind.pop_front();
      longint e = qEdge.pop_front();
      chk(k == kind, req, kind, k);
      chk(e == edgeNo, req, edgeNo, e);
    end
  endtask

  // monitor
  bit     hsPrev = 0, vsPrev = 0, dePrev = 0;
  int     hsPulses = 0;
  longint lastPix = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (hsync && !hsPrev) begin expectEvt(K_HSR, "R3"); hsPulses = 0; end
      if (!hsync && hsPrev) chk(hsPulses == int'(hsWidth), "R4", hsPulses, hsWidth);
      if (hsync && pixEn) hsPulses++;
      if (vsync && !vsPrev) expectEvt(K_VSR, "R5");
      if (!vsync && vsPrev) expectEvt(K_VSF, "R5");
      if (de && !dePrev) expectEvt(K_DER, burstMode ? "R8" : "R7");
      if (!de && dePrev) expectEvt(K_DEF, "R9");
      if (pixEn) begin
        if (pixRestart) pixRestart = 0;
        else chk(edgeNo - lastPix == longint'(pixDiv), "R6", edgeNo - lastPix, pixDiv);
        lastPix = edgeNo;
      end
    end
    hsPrev = hsync; vsPrev = vsync; dePrev = de;
  end

  task automatic push(input int kind, input longint e);
    qKind.push_back(kind);
    qEdge.push_back(e);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit start, output longint e);
    @(negedge clk);
    byteIn = b; byteValid = 1'b1; pktStart = start;
    e = edgeNo + 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byteValid = 1'b0; pktStart = 1'b0; byteIn = 8'h21;
    end
  endtask

  task automatic shortPkt(input logic [7:0] id);
    longint e;
    sendByte(id, 1, e);
    sendByte(8'h01, 0, e);
    sendByte(8'h19, 0, e);
    if (id[5:0] == 6'h21) push(K_HSR, e + 1);
    if (id[5:0] == 6'h01 && !expVs) begin push(K_VSR, e + 1); expVs = 1; end
    if (id[5:0] == 6'h11 && expVs) begin push(K_VSF, e + 1); expVs = 0; end
    sendByte(8'h3C, 0, e);
  endtask

  task automatic longPkt(input logic [7:0] id, input int wc, input logic [7:0] fill, input int gapAt);
    longint e;
    sendByte(id, 1, e);
    sendByte(8'(wc), 0, e);
    sendByte(8'(wc >> 8), 0, e);
    sendByte(8'h2A, 0, e);
    if (id[5:0] == 6'h19 && expDe) begin push(K_DEF, e); expDe = 0; end
    for (int i = 0; i < wc; i++) begin
      if (i == gapAt) idle(2);
      sendByte((i % 2 == 0) ? fill : 8'h01, 0, e);
      if (id[5:0] == 6'h3E && !expDe && ((burstMode && i == 0) || (!burstMode && i == 5))) begin
        push(K_DER, e); expDe = 1;
      end
    end
    sendByte(8'h55, 0, e);
    sendByte(8'hAA, 0, e);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!hsync && !vsync && !de && !pixEn, "R1", {hsync, vsync, de, pixEn}, 0);
    rstN = 1'b1;
    idle(10);

    // non-burst line 1: header-like payload bytes (R10), R7 delayed start
    shortPkt(8'h01);
    idle(20);
    shortPkt(8'h21);
    idle(20);
    shortPkt(8'h31);
    idle(3);
    chk(hsync == 0, "R4", hsync, 0);
    longPkt(8'h19, 4, 8'h21, -1);
    chk(de == 0, "R9", de, 0);
    longPkt(8'h3E, 12, 8'h21, -1);
    longPkt(8'h19, 3, 8'h01, -1);

    // line 2: pause inside payload (R2)
    shortPkt(8'h21);
    idle(20);
    longPkt(8'h3E, 9, 8'h19, 3);
    longPkt(8'h19, 2, 8'h00, -1);

    // line 3: short pixel packet, R11
    shortPkt(8'h21);
    idle(20);
    longPkt(8'h3E, 4, 8'h21, -1);
    idle(2);
    chk(de == 0, "R11", de, 0);
    longPkt(8'h19, 2, 8'h00, -1);

    // line 4: non-pixel long packet, R10
    longPkt(8'h29, 8, 8'h21, -1);
    idle(2);
    chk(de == 0, "R10", de, 0);

    // burst lines: R8
    idle(2);
    burstMode = 1'b1; pixDiv = 4'd3; hsWidth = 8'd5; pixRestart = 1;
    idle(10);
    shortPkt(8'h21);
    idle(20);
    longPkt(8'h3E, 6, 8'h11, -1);
    idle(15);
    longPkt(8'h19, 3, 8'h00, -1);
    shortPkt(8'hE1); // upper bits ignored, R2
    idle(20);
    longPkt(8'h3E, 1, 8'h01, -1);
    idle(8);
    longPkt(8'h19, 0, 8'h00, -1);
    shortPkt(8'h11);
    idle(40);
    chk(qKind.size() == 0, "R2", qKind.size(), 0);
    chk(!de && !vsync && !hsync, "R9", {hsync, vsync, de}, 0);
    finishRun();
  end
endmodule